// File: doc/BRIEF.md
# Precise exception controller for a five-stage in-order pipeline

This block sequences faults and interrupts for an in-order pipeline with fetch, decode, execute, memory and write-back stages. It keeps a small tag register per stage: a valid bit, the instruction address, a fault flag, a return-from-exception flag and a cause code. The datapath reports faults through one strobe per stage. An instruction-translation fault is reported in fetch, an illegal opcode in decode, arithmetic overflow in execute and a data-translation fault in memory. The strobe marks the instruction that holds that stage in that cycle. A tagged instruction keeps moving and nothing acts on the tag before the instruction reaches write-back. In-order retirement therefore always resolves the oldest faulting instruction first, even when a younger one was flagged earlier in time.

An external interrupt request is a held level. While interrupts are enabled, the block puts a marked no-op into the fetch register in place of the fetched instruction. The no-op carries that instruction's address and the interrupt cause. It then moves down the pipe as a faulting entry. When a faulting entry reaches write-back, the block redirects fetch to a fixed vector and invalidates every younger stage in the same cycle. It also records the address and cause, enters supervisor mode and masks interrupts. A non-faulting return-from-exception entry at write-back redirects to the saved address, restores user mode and re-enables interrupts.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset, all five stages are empty, the block is in supervisor mode with interrupts masked, the saved address and cause are 0, and no redirect is requested.
- R2: A fetched instruction moves one stage per clock (stage_valid_o bit 0 = fetch, bit 4 = write-back) and is presented in write-back on the fifth cycle after fetch; an untagged entry there raises wb_commit_o, and an untagged entry in the memory stage raises mem_store_ok_o.
- R3: A fault strobe tags the instruction in that stage with cause 1 (fetch translation), 2 (illegal), 3 (overflow) or 4 (data translation), and no redirect occurs until that instruction is in write-back.
- R4: An instruction already tagged keeps its first cause when a later stage also flags it.
- R5: When two instructions fault, the older one is taken even if the younger was flagged first, and the younger is discarded.
- R6: A tagged entry in write-back raises redirect_o with the vector address, suppresses wb_commit_o and mem_store_ok_o in that cycle, and on the next clock sets the saved address and cause from that entry, enters supervisor mode, masks interrupts and leaves every stage empty.
- R7: With the request high, interrupts enabled, no marked no-op in the pipe and no redirect in progress, irq_inject_o is high and the fetch register captures a marked no-op with cause 0 and the presented fetch address.
- R8: While interrupts are masked, a held request injects nothing and causes no redirect.
- R9: At most one marked no-op is in the pipe at a time.
- R10: A marked no-op discarded by an older fault is injected again once a return re-enables interrupts, provided the request is still held.
- R11: A return entry that reaches write-back untagged raises redirect_o with the saved address, commits, and on the next clock selects user mode, enables interrupts and leaves every stage empty.
- R12: A return decoded in user mode is tagged illegal (cause 2) rather than executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | An instruction is presented to fetch this cycle |
| fetch_pc_i | input | PC_W | Address of the presented instruction |
| irq_i | input | 1 | Level-held external interrupt request |
| itlb_fault_i | input | 1 | Translation fault for the entry in fetch |
| illegal_i | input | 1 | Illegal opcode for the entry in decode |
| rfe_i | input | 1 | Entry in decode is a return-from-exception |
| ovf_i | input | 1 | Overflow for the entry in execute |
| dtlb_fault_i | input | 1 | Translation fault for the entry in memory |
| stage_valid_o | output | 5 | Occupancy per stage, bit 0 fetch to bit 4 write-back |
| mem_store_ok_o | output | 1 | Memory-stage entry may perform its store |
| wb_commit_o | output | 1 | Write-back entry may update architectural state |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | Restart address |
| epc_o | output | PC_W | Saved exception address |
| cause_o | output | 3 | Saved cause code |
| supervisor_o | output | 1 | Supervisor mode is active |
| irq_en_o | output | 1 | Interrupts are enabled |
| irq_inject_o | output | 1 | A marked no-op replaces the fetch this cycle |

## Verification
The bench uses the defaults: a 32-bit address and the vector at 0x80, away from every address it fetches. Each run therefore shows from the redirect target alone which path was taken. It also shows from the saved address alone which instruction won an ordering race. The full address width lets each scenario use its own address, so a stale saved address never looks like a correct one.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

  localparam int NSTAGE = 5;
  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MEM = 3;
  localparam int ST_WB  = 4;

  typedef enum logic [2:0] {
    CAUSE_INT  = 3'd0,
    CAUSE_ITLB = 3'd1,
    CAUSE_ILL  = 3'd2,
    CAUSE_OVF  = 3'd3,
    CAUSE_DTLB = 3'd4
  } cause_e;

  typedef struct packed {
    logic   valid;
    logic   exc;
    logic   rfe;
    cause_e cause;
  } tag_t;

  // Cause reported by the fault strobe that belongs to a given stage.
  function automatic cause_e stage_cause(input int s);
    case (s)
      ST_IF:   return CAUSE_ITLB;
      ST_ID:   return CAUSE_ILL;
      ST_EX:   return CAUSE_OVF;
      ST_MEM:  return CAUSE_DTLB;
      default: return CAUSE_INT;
    endcase
  endfunction

endpackage

// File: rtl/pexc_stage.sv
module pexc_stage
  import pexc_pkg::*;
#(
  parameter int     PC_W        = 32,
  parameter cause_e FAULT_CAUSE = CAUSE_INT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  tag_t            ld_tag,
  input  logic [PC_W-1:0] ld_pc,
  input  logic            fault,
  input  logic            rfe_mark,
  output tag_t            out_tag,
  output logic [PC_W-1:0] out_pc
);

  tag_t            tag_q, tag_d;
  logic [PC_W-1:0] pc_q;
  logic            pc_en;

  // Next state: a squash empties the stage, otherwise take the older neighbour.
  always_comb begin
    tag_d = ld_tag;
    if (flush) tag_d = '0;
  end

  assign pc_en = ld_tag.valid & ~flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  always_ff @(posedge clk) begin
    if (pc_en) pc_q <= ld_pc;
  end

  // First fault wins: a tag already set is never overwritten.
  always_comb begin
    out_tag = tag_q;
    if (tag_q.valid && !tag_q.exc) begin
      if (fault) begin
        out_tag.exc   = 1'b1;
        out_tag.cause = FAULT_CAUSE;
      end else if (rfe_mark) begin
        out_tag.rfe = 1'b1;
      end
    end
  end

  assign out_pc = pc_q;

endmodule

// File: rtl/pexc_inject.sv
module pexc_inject
  import pexc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            irq_i,
  input  logic            irq_en,
  input  logic            inflight,
  input  logic            squash,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output tag_t            if_tag,
  output logic [PC_W-1:0] if_pc,
  output logic            inject
);

  assign inject = irq_i & irq_en & ~inflight & ~squash;

  always_comb begin
    if_tag       = '0;
    if_tag.cause = CAUSE_INT;
    if (inject) begin
      if_tag.valid = 1'b1;
      if_tag.exc   = 1'b1;
    end else begin
      if_tag.valid = fetch_valid;
    end
  end

  // The marked no-op stands for the displaced instruction, so it keeps its address.
  assign if_pc = fetch_pc;

endmodule

// File: rtl/pexc_csr.sv
module pexc_csr
  import pexc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_exc,
  input  logic            take_rfe,
  input  logic [PC_W-1:0] wb_pc,
  input  cause_e          wb_cause,
  output logic [PC_W-1:0] epc,
  output cause_e          cause,
  output logic            supervisor,
  output logic            irq_en
);

  logic [PC_W-1:0] epc_q, epc_d;
  cause_e          cause_q, cause_d;
  logic            sup_q, sup_d;
  logic            ie_q, ie_d;

  always_comb begin
    epc_d   = epc_q;
    cause_d = cause_q;
    sup_d   = sup_q;
    ie_d    = ie_q;
    if (take_exc) begin
      epc_d   = wb_pc;
      cause_d = wb_cause;
      sup_d   = 1'b1;
      ie_d    = 1'b0;
    end else if (take_rfe) begin
      sup_d   = 1'b0;
      ie_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CAUSE_INT;
      sup_q   <= 1'b1;
      ie_q    <= 1'b0;
    end else begin
      sup_q <= sup_d;
      ie_q  <= ie_d;
      if (take_exc) begin
        epc_q   <= epc_d;
        cause_q <= cause_d;
      end
    end
  end

  assign epc        = epc_q;
  assign cause      = cause_q;
  assign supervisor = sup_q;
  assign irq_en     = ie_q;

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
  import pexc_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] VECTOR_PC = 'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            irq_i,
  input  logic            itlb_fault_i,
  input  logic            illegal_i,
  input  logic            rfe_i,
  input  logic            ovf_i,
  input  logic            dtlb_fault_i,
  output logic [4:0]      stage_valid_o,
  output logic            mem_store_ok_o,
  output logic            wb_commit_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [2:0]      cause_o,
  output logic            supervisor_o,
  output logic            irq_en_o,
  output logic            irq_inject_o
);

  tag_t              stg_tag [NSTAGE];
  logic [PC_W-1:0]   stg_pc  [NSTAGE];
  logic [NSTAGE-1:0] stg_fault;
  logic [NSTAGE-1:0] stg_rfe;
  logic [NSTAGE-1:0] irq_marks;

  tag_t              if_tag;
  logic [PC_W-1:0]   if_pc;
  logic              inflight;
  logic              take_exc, take_rfe, squash;
  tag_t              wb_tag;
  logic [PC_W-1:0]   wb_pc;
  cause_e            csr_cause;
  logic              sup, ie;

  // A return seen in user mode is privileged and becomes an illegal-opcode fault.
  assign stg_fault = {1'b0, dtlb_fault_i, ovf_i, illegal_i | (rfe_i & ~sup), itlb_fault_i};
  assign stg_rfe   = NSTAGE'(rfe_i) << ST_ID;

  assign wb_tag   = stg_tag[ST_WB];
  assign wb_pc    = stg_pc[ST_WB];
  assign take_exc = wb_tag.valid & wb_tag.exc;
  assign take_rfe = wb_tag.valid & ~wb_tag.exc & wb_tag.rfe;
  assign squash   = take_exc | take_rfe;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    tag_t            ld_tag;
    logic [PC_W-1:0] ld_pc;
    if (g == ST_IF) begin : g_head
      assign ld_tag = if_tag;
      assign ld_pc  = if_pc;
    end else begin : g_chain
      assign ld_tag = stg_tag[g-1];
      assign ld_pc  = stg_pc[g-1];
    end

    pexc_stage #(
      .PC_W        (PC_W),
      .FAULT_CAUSE (stage_cause(g))
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (squash),
      .ld_tag   (ld_tag),
      .ld_pc    (ld_pc),
      .fault    (stg_fault[g]),
      .rfe_mark (stg_rfe[g]),
      .out_tag  (stg_tag[g]),
      .out_pc   (stg_pc[g])
    );

    assign stage_valid_o[g] = stg_tag[g].valid;
    assign irq_marks[g]     = stg_tag[g].valid & stg_tag[g].exc &
                              (stg_tag[g].cause == CAUSE_INT);
  end

  assign inflight = |irq_marks;

  pexc_inject #(.PC_W(PC_W)) u_inject (
    .irq_i       (irq_i),
    .irq_en      (ie),
    .inflight    (inflight),
    .squash      (squash),
    .fetch_valid (fetch_valid_i),
    .fetch_pc    (fetch_pc_i),
    .if_tag      (if_tag),
    .if_pc       (if_pc),
    .inject      (irq_inject_o)
  );

  pexc_csr #(.PC_W(PC_W)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_exc   (take_exc),
    .take_rfe   (take_rfe),
    .wb_pc      (wb_pc),
    .wb_cause   (wb_tag.cause),
    .epc        (epc_o),
    .cause      (csr_cause),
    .supervisor (sup),
    .irq_en     (ie)
  );

  assign cause_o       = csr_cause;
  assign supervisor_o  = sup;
  assign irq_en_o      = ie;
  assign redirect_o    = squash;
  assign redirect_pc_o = take_exc ? VECTOR_PC : epc_o;
  assign wb_commit_o   = wb_tag.valid & ~wb_tag.exc;
  assign mem_store_ok_o = stg_tag[ST_MEM].valid & ~stg_tag[ST_MEM].exc & ~squash;

endmodule

// File: rtl/precise_exc_ctrl_chk.sv
module precise_exc_ctrl_chk #(
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] VECTOR_PC = 'h80
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_exc,
  input logic            take_rfe,
  input logic [PC_W-1:0] wb_pc,
  input logic            irq_i,
  input logic [4:0]      stage_valid_o,
  input logic            mem_store_ok_o,
  input logic            wb_commit_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [PC_W-1:0] epc_o,
  input logic            supervisor_o,
  input logic            irq_en_o,
  input logic            irq_inject_o
);

  a_r6_no_write_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> !wb_commit_o && !mem_store_ok_o);

  a_r6_vector_target: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> redirect_o && redirect_pc_o == VECTOR_PC);

  a_r6_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> supervisor_o && !irq_en_o && stage_valid_o == 5'b0 && epc_o == $past(wb_pc));

  a_r7_inject_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inject_o |-> irq_i && irq_en_o);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_o |-> !irq_inject_o);

  a_r9_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
    irq_inject_o |=> !irq_inject_o);

  a_r11_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    take_rfe |-> redirect_o && redirect_pc_o == epc_o);

  a_r11_return_state: assert property (@(posedge clk) disable iff (!rst_n)
    take_rfe |=> !supervisor_o && irq_en_o && stage_valid_o == 5'b0);

endmodule

bind precise_exc_ctrl precise_exc_ctrl_chk #(
  .PC_W      (PC_W),
  .VECTOR_PC (VECTOR_PC)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .take_exc       (take_exc),
  .take_rfe       (take_rfe),
  .wb_pc          (wb_pc),
  .irq_i          (irq_i),
  .stage_valid_o  (stage_valid_o),
  .mem_store_ok_o (mem_store_ok_o),
  .wb_commit_o    (wb_commit_o),
  .redirect_o     (redirect_o),
  .redirect_pc_o  (redirect_pc_o),
  .epc_o          (epc_o),
  .supervisor_o   (supervisor_o),
  .irq_en_o       (irq_en_o),
  .irq_inject_o   (irq_inject_o)
);

// File: tb/precise_exc_ctrl_tb.sv
`timescale 1ns/1ps
module precise_exc_ctrl_tb;

  localparam logic [31:0] VEC_PC = 32'h80;

  // {fault mask[3:0] (bit0 fetch .. bit3 memory), taken, expected cause[2:0]}
  localparam logic [7:0] VEC [7] = '{
    8'b0001_1_001,
    8'b0010_1_010,
    8'b0100_1_011,
    8'b1000_1_100,
    8'b0101_1_001,
    8'b1100_1_011,
    8'b0000_0_000
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, irq, itlb, ill, rfe, ovf, dtlb;
  logic [31:0] fetch_pc;
  logic [4:0]  stage_valid;
  logic        mem_store_ok, wb_commit, redirect, supervisor, irq_en, irq_inject;
  logic [31:0] redirect_pc, epc;
  logic [2:0]  cause;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  precise_exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_pc_i(fetch_pc), .irq_i(irq),
    .itlb_fault_i(itlb), .illegal_i(ill), .rfe_i(rfe), .ovf_i(ovf), .dtlb_fault_i(dtlb),
    .stage_valid_o(stage_valid), .mem_store_ok_o(mem_store_ok), .wb_commit_o(wb_commit),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .epc_o(epc), .cause_o(cause),
    .supervisor_o(supervisor), .irq_en_o(irq_en), .irq_inject_o(irq_inject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Fetch one instruction; returns in the cycle it occupies write-back.
  task automatic issue(input logic [31:0] pc, input logic is_rfe);
    fetch_valid = 1'b1; fetch_pc = pc; step();
    fetch_valid = 1'b0; step();
    rfe = is_rfe; step();
    rfe = 1'b0; step();
    step();
    #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch_valid = 0; fetch_pc = 0; irq = 0;
    itlb = 0; ill = 0; rfe = 0; ovf = 0; dtlb = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step(); #1;
    chk("R1 stages empty", stage_valid, 0);
    chk("R1 supervisor", supervisor, 1);
    chk("R1 irq masked", irq_en, 0);
    chk("R1 epc", epc, 0);
    chk("R1 cause", cause, 0);
    chk("R1 no redirect", redirect, 0);

    // Table walk: one instruction per entry, faults by stage.
    for (int i = 0; i < 7; i++) begin
      logic [3:0]  m;
      logic        tk;
      logic [2:0]  cz;
      logic [31:0] pc;
      m = VEC[i][7:4]; tk = VEC[i][3]; cz = VEC[i][2:0];
      pc = 32'h100 + 32'(i) * 16;
      fetch_valid = 1'b1; fetch_pc = pc; step();
      fetch_valid = 1'b0;
      for (int s = 0; s < 4; s++) begin
        itlb = m[0] && (s == 0);
        ill  = m[1] && (s == 1);
        ovf  = m[2] && (s == 2);
        dtlb = m[3] && (s == 3);
        #1;
        chk("R3 deferred to WB", redirect, 0);
        if (!tk) begin
          chk("R2 stage walk", stage_valid, 32'(1) << s);
          if (s == 3) chk("R2 clean store", mem_store_ok, 1);
        end
        step();
      end
      itlb = 0; ill = 0; ovf = 0; dtlb = 0; #1;
      chk("R3 take at WB", redirect, tk);
      chk("R2 commit", wb_commit, !tk);
      if (tk) chk("R6 vector", redirect_pc, VEC_PC);
      step(); #1;
      if (tk) begin
        chk("R6 epc", epc, pc);
        chk("R3 R4 cause", cause, cz);
        chk("R6 supervisor", supervisor, 1);
        chk("R6 stages empty", stage_valid, 0);
      end
    end

    // R11: return to user; a younger fetch in the same cycle is dropped.
    issue(32'h400, 1'b1);
    chk("R11 redirect", redirect, 1);
    chk("R11 target", redirect_pc, 32'h150);
    chk("R11 commit", wb_commit, 1);
    fetch_valid = 1'b1; fetch_pc = 32'h999;
    step(); fetch_valid = 1'b0; #1;
    chk("R11 user", supervisor, 0);
    chk("R11 irq enabled", irq_en, 1);
    chk("R11 squash", stage_valid, 0);

    // R12: return in user mode is illegal.
    issue(32'h500, 1'b1);
    chk("R12 vector", redirect_pc, VEC_PC);
    chk("R12 no commit", wb_commit, 0);
    step(); #1;
    chk("R12 cause", cause, 2);
    chk("R12 epc", epc, 32'h500);
    chk("R12 supervisor", supervisor, 1);
    issue(32'h510, 1'b1);
    chk("R11 target epc", redirect_pc, 32'h500);
    step(); #1;

    // R7 / R9 / R8: interrupt injection.
    irq = 1'b1; fetch_valid = 1'b1; fetch_pc = 32'h600; #1;
    chk("R7 inject", irq_inject, 1);
    step(); fetch_valid = 1'b0; #1;
    chk("R9 single marker", irq_inject, 0);
    chk("R7 marker in fetch", stage_valid, 1);
    repeat (4) step();
    #1;
    chk("R7 redirect", redirect, 1);
    chk("R7 vector", redirect_pc, VEC_PC);
    step(); #1;
    chk("R7 epc", epc, 32'h600);
    chk("R7 cause", cause, 0);
    for (int k = 0; k < 6; k++) begin
      chk("R8 masked inject", irq_inject, 0);
      chk("R8 masked redirect", redirect, 0);
      step(); #1;
    end
    irq = 1'b0;
    issue(32'h610, 1'b1);
    step(); #1;

    // R5 / R10: older data fault beats a younger marked no-op.
    fetch_valid = 1'b1; fetch_pc = 32'h700; step();
    fetch_pc = 32'h704; irq = 1'b1; #1;
    chk("R10 first inject", irq_inject, 1);
    step(); fetch_valid = 1'b0; #1;
    chk("R9 no second", irq_inject, 0);
    step(); step();
    dtlb = 1'b1; step();
    dtlb = 1'b0; #1;
    chk("R5 redirect", redirect, 1);
    step(); #1;
    chk("R5 oldest epc", epc, 32'h700);
    chk("R5 oldest cause", cause, 4);
    chk("R10 marker squashed", stage_valid, 0);
    issue(32'h720, 1'b1);
    chk("R11 redirect", redirect, 1);
    step(); fetch_valid = 1'b1; fetch_pc = 32'h730; #1;
    chk("R10 reinject", irq_inject, 1);
    step(); fetch_valid = 1'b0;
    repeat (4) step();
    #1;
    chk("R10 redirect", redirect, 1);
    step(); irq = 1'b0; #1;
    chk("R10 epc", epc, 32'h730);
    chk("R10 cause", cause, 0);

    // R5: younger flagged first, older still wins.
    fetch_valid = 1'b1; fetch_pc = 32'h800; step();
    fetch_pc = 32'h804; step();
    fetch_valid = 1'b0; itlb = 1'b1; step();
    itlb = 1'b0; step();
    dtlb = 1'b1; step();
    dtlb = 1'b0; #1;
    chk("R5 redirect", redirect, 1);
    step(); #1;
    chk("R5 epc", epc, 32'h800);
    chk("R5 cause", cause, 4);
    step(); #1;
    chk("R5 younger dropped", redirect, 0);

    // R6: clean younger entry in memory loses its store during a take.
    fetch_valid = 1'b1; fetch_pc = 32'h900; step();
    fetch_pc = 32'h904; step();
    fetch_valid = 1'b0; step();
    ovf = 1'b1; step();
    ovf = 1'b0; #1;
    chk("R6 tagged no store", mem_store_ok, 0);
    step(); #1;
    chk("R6 younger no store", mem_store_ok, 0);
    chk("R6 no commit", wb_commit, 0);
    step(); #1;
    chk("R6 overflow cause", cause, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule